// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block is the digital control front end of a 6-bit binary-weighted step attenuator. It produces a registered attenuation code whose bits would drive the bypass switches of the six attenuator cells. A mode input picks the control path. One path is a 3-wire serial port made of a data input, a serial clock and a latch-enable strobe. The other path is a 6-line parallel port that can run either transparent or latched.

The latch-enable strobe has three jobs. In serial mode its rising edge commits the shifted word, and while it stays high it masks the serial clock. In parallel mode its level decides whether the code follows the data lines or holds them. A serial output passes each shifted bit on after eight shifts, so several devices can share one serial bus in a daisy chain.

Everything runs on one system clock. That clock samples the serial clock, the strobe, the mode input and the data lines through a synchroniser, and detects edges after it. A four-state controller is encoded from the synchronised {mode, strobe} pair:
- `ST_PAR_HOLD`: parallel, strobe low. The code is held.
- `ST_PAR_FOLLOW`: parallel, strobe high. The code tracks the data lines.
- `ST_SER_SHIFT`: serial, strobe low. Serial clock rises shift data in.
- `ST_SER_LOAD`: serial, strobe high. The serial clock is masked.

Transitions follow the synchronised inputs directly. The transition `ST_SER_SHIFT -> ST_SER_LOAD` commits the word. Every cycle spent in `ST_PAR_FOLLOW` loads the data lines. Every other transition, including any change of mode, leaves the code untouched.

Top module: `attn_ctl`

## Requirements
- R1: After reset, `atten_code` is 0 (the reference state, no attenuation) and `ser_dout` is 0.
- R2: `mode_serial` = 1 selects the serial path and `mode_serial` = 0 selects the parallel path.
- R3: `atten_code` bit i weighs 0.5 dB × 2^i: bit 0 is 0.5 dB and bit 5 is 16 dB, so 6'h3F is 31.5 dB. The code keeps the bit order of `par_code` and of the shifted word without reordering.
- R4: In serial mode with `latch_en` low, each rising `ser_clk` shifts `ser_din` into an 8-bit register, most significant bit first. In an 8-bit word, the first two bits shifted have no effect on the code.
- R5: A 6-bit serial word is also accepted. Only the last six bits shifted before the commit set the code.
- R6: In serial mode, a rising `latch_en` copies the low six bits of the shift register into `atten_code`. The code then holds until the next commit.
- R7: While `latch_en` is high in serial mode, `ser_clk` edges shift nothing. `ser_dout` stays unchanged, and a later commit loads the earlier word.
- R8: After each shift, `ser_dout` equals the bit that was shifted in eight shifts earlier. Before eight shifts have happened, it equals 0.
- R9: In parallel mode with `latch_en` high, `atten_code` follows `par_code`.
- R10: In parallel mode with `latch_en` low, `atten_code` holds while `par_code` changes. A high pulse on `latch_en` loads the value present at that time.
- R11: A change of `mode_serial` does not alter `atten_code`. The code changes only on a later commit or a parallel update.
- R12: An input change made just after a rising `clk` reaches `atten_code` or `ser_dout` by the third rising `clk` edge (two synchroniser stages plus one register).
- R13: In parallel mode, `ser_clk` edges shift nothing. `ser_dout` and the shift register contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all control inputs |
| rst_n | input | 1 | Active-low reset |
| mode_serial | input | 1 | 1 selects the serial path, 0 selects the parallel path |
| latch_en | input | 1 | Commit strobe, serial clock mask and parallel transparency control |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_din | input | 1 | Serial data input, most significant bit first |
| par_code | input | 6 | Parallel attenuation code |
| ser_dout | output | 1 | Daisy-chain output, eight shifts behind `ser_din` |
| atten_code | output | 6 | Registered attenuation code, 0.5 dB per LSB |

## Verification
A wrong shift-register bit stays hidden until it either reaches `ser_dout`, which takes up to eight shifts, or is committed, after which it shows in `atten_code` three clocks after the strobe rises. A wrong controller state shows within three clocks. In that case the code either moves while it should hold, for example on a mode change or during latched-parallel setup, or fails to follow the parallel lines. Mask leaks are caught through `ser_dout` right after the masked clock pulse. They are also caught by a re-commit that must reproduce the earlier word.

// File: rtl/attn_ctl_pkg.sv
`timescale 1ns/1ps
package attn_ctl_pkg;
    // Encoding is {mode_serial, latch_en} after synchronisation.
    typedef enum logic [1:0] {
        ST_PAR_HOLD   = 2'b00,
        ST_PAR_FOLLOW = 2'b01,
        ST_SER_SHIFT  = 2'b10,
        ST_SER_LOAD   = 2'b11
    } ctl_state_t;
endpackage

// File: rtl/attn_sync.sv
`timescale 1ns/1ps
module attn_sync #(
    parameter int WIDTH  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/attn_shift.sv
`timescale 1ns/1ps
module attn_shift #(
    parameter int SHIFT_LEN = 8,
    parameter int CODE_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [CODE_W-1:0] code_low,
    output logic              dout
);
    logic [SHIFT_LEN-1:0] shreg_q;
    logic                 dout_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            dout_q  <= 1'b0;
        end else if (shift_en) begin
            // the bit pushed off the top is the one shifted in SHIFT_LEN shifts ago
            dout_q  <= shreg_q[SHIFT_LEN-1];
            shreg_q <= {shreg_q[SHIFT_LEN-2:0], din};
        end
    end

    assign code_low = shreg_q[CODE_W-1:0];
    assign dout     = dout_q;
endmodule

// File: rtl/attn_ctl.sv
`timescale 1ns/1ps
module attn_ctl
    import attn_ctl_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int SHIFT_LEN   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_serial,
    input  logic              latch_en,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic [CODE_W-1:0] par_code,
    output logic              ser_dout,
    output logic [CODE_W-1:0] atten_code
);
    localparam int SYNC_W = CODE_W + 4;

    logic [SYNC_W-1:0] raw_bus, syn_bus;
    logic              mode_s, le_s, sclk_s, sdi_s;
    logic [CODE_W-1:0] par_s;
    logic              sclk_prev_q, sclk_rise, shift_en;
    logic [CODE_W-1:0] shift_low;
    logic [CODE_W-1:0] atten_q, atten_d;
    ctl_state_t        state_q, state_d;

    assign raw_bus = {mode_serial, latch_en, ser_clk, ser_din, par_code};

    attn_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_bus),
        .d_out (syn_bus)
    );

    assign {mode_s, le_s, sclk_s, sdi_s, par_s} = syn_bus;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_s;
    end
    assign sclk_rise = sclk_s & ~sclk_prev_q;

    // next state comes straight from the synchronised {mode, strobe} pair
    assign state_d = ctl_state_t'({mode_s, le_s});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PAR_HOLD;
        else        state_q <= state_d;
    end

    assign shift_en = (state_d == ST_SER_SHIFT) && sclk_rise;

    attn_shift #(.SHIFT_LEN(SHIFT_LEN), .CODE_W(CODE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (sdi_s),
        .code_low (shift_low),
        .dout     (ser_dout)
    );

    always_comb begin
        atten_d = atten_q;
        unique case (state_d)
            ST_PAR_HOLD:   atten_d = atten_q;
            ST_PAR_FOLLOW: atten_d = par_s;
            ST_SER_SHIFT:  atten_d = atten_q;
            ST_SER_LOAD:   if (state_q == ST_SER_SHIFT) atten_d = shift_low;
            default:       atten_d = atten_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) atten_q <= '0;
        else        atten_q <= atten_d;
    end

    assign atten_code = atten_q;

    // strobe held high in serial mode: no shifting reaches the output
    assert_mask_sdo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SER_LOAD && state_d == ST_SER_LOAD) |=> $stable(ser_dout));

    assert_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SER_SHIFT && state_d == ST_SER_LOAD) |=> atten_code == $past(shift_low));

    assert_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d == ST_PAR_FOLLOW) |=> atten_code == $past(par_s));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAR_HOLD && state_d == ST_PAR_HOLD) |=> $stable(atten_code));

    // entering serial without a strobe rise (mode change included) keeps the code
    assert_mode_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d == ST_SER_SHIFT || (state_d == ST_SER_LOAD && state_q != ST_SER_SHIFT))
        |=> $stable(atten_code));

    assert_par_noshift_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_s) |=> $stable(ser_dout));
endmodule

// File: tb/attn_ctl_tb.sv
`timescale 1ns/1ps
module attn_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_serial = 1'b0, latch_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
    logic [5:0] par_code = '0;
    logic       ser_dout;
    logic [5:0] atten_code;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] exp_shift = '0;
    logic       exp_sdo   = 1'b0;
    logic [5:0] exp_atten = '0;

    always #2.5 clk = ~clk;

    attn_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .mode_serial(mode_serial), .latch_en(latch_en),
        .ser_clk(ser_clk), .ser_din(ser_din), .par_code(par_code),
        .ser_dout(ser_dout), .atten_code(atten_code)
    );

    function automatic logic [5:0] commit_of(input logic [7:0] sh);
        return sh[5:0];
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ser_bit(input logic b, input string tag);
        ser_din = b;
        tick(4);
        ser_clk = 1'b1;
        tick(4);
        ser_clk = 1'b0;
        tick(4);
        if (mode_serial && !latch_en) begin
            exp_sdo   = exp_shift[7];
            exp_shift = {exp_shift[6:0], b};
        end
        check(tag, {7'd0, ser_dout}, {7'd0, exp_sdo});
    endtask

    task automatic ser_word(input logic [7:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) ser_bit(w[i], "R8 sdo delay");
    endtask

    task automatic strobe_pulse();
        latch_en = 1'b1;
        tick(4);
        if (mode_serial) exp_atten = commit_of(exp_shift);
        else             exp_atten = par_code;
        latch_en = 1'b0;
        tick(4);
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd51966);
        tick(3);
        check("R1 reset code", {2'b0, atten_code}, 8'h00);
        check("R1 reset sdo", {7'd0, ser_dout}, 8'h00);
        rst_n = 1'b1;
        tick(2);

        // R2/R4: serial 8-bit word, top two bits are don't care
        mode_serial = 1'b1;
        tick(4);
        ser_word(8'hEA, 8);
        check("R4 code before commit", {2'b0, atten_code}, 8'h00);
        strobe_pulse();
        check("R4 8-bit word ignores top two", {2'b0, atten_code}, 8'h2A);
        check("R6 commit", {2'b0, atten_code}, {2'b0, exp_atten});

        // R5: 6-bit word
        ser_word(8'h15, 6);
        strobe_pulse();
        check("R5 6-bit word", {2'b0, atten_code}, 8'h15);

        // R3: full-scale and single weights via serial
        ser_word(8'h3F, 8);
        strobe_pulse();
        check("R3 full scale 31.5 dB", {2'b0, atten_code}, 8'h3F);

        // R7: masked serial clock while strobe high
        ser_word(8'h01, 8);
        strobe_pulse();
        check("R7 pre-mask commit", {2'b0, atten_code}, 8'h01);
        latch_en = 1'b1;
        tick(4);
        ser_bit(1'b1, "R7 sdo masked");
        ser_bit(1'b1, "R7 sdo masked");
        check("R7 code held under mask", {2'b0, atten_code}, 8'h01);
        latch_en = 1'b0;
        tick(4);
        strobe_pulse();
        check("R7 recommit unchanged word", {2'b0, atten_code}, 8'h01);

        // R8: sdo chain of sixteen bits
        ser_word(8'hC3, 8);
        ser_word(8'h5A, 8);
        check("R8 sdo after 16 shifts", {7'd0, ser_dout}, {7'd0, 1'b1});

        // R11: mode change with strobe low keeps code
        strobe_pulse();
        check("R6 commit 5A low bits", {2'b0, atten_code}, 8'h1A);
        mode_serial = 1'b0;
        par_code = 6'h07;
        tick(4);
        check("R11 serial->parallel keeps code", {2'b0, atten_code}, 8'h1A);

        // R13: serial clock ignored in parallel mode
        ser_bit(1'b0, "R13 sdo unchanged in parallel");
        ser_bit(1'b1, "R13 sdo unchanged in parallel");

        // R10: latched parallel
        par_code = 6'h24;
        tick(4);
        check("R10 setup hold", {2'b0, atten_code}, 8'h1A);
        strobe_pulse();
        check("R10 pulse loads", {2'b0, atten_code}, 8'h24);
        par_code = 6'h11;
        tick(4);
        check("R10 holds after pulse", {2'b0, atten_code}, 8'h24);

        // R9/R12: direct parallel with latency
        latch_en = 1'b1;
        tick(4);
        exp_atten = 6'h11;
        check("R9 follow on strobe high", {2'b0, atten_code}, 8'h11);
        par_code = 6'h20;
        tick(3);
        check("R12 latency 3 edges", {2'b0, atten_code}, 8'h20);
        par_code = 6'h01;
        tick(3);
        check("R3 LSB weight bit0", {2'b0, atten_code}, 8'h01);

        // R11: parallel->serial with strobe low keeps code; R13 shift reg untouched
        latch_en = 1'b0;
        tick(4);
        mode_serial = 1'b1;
        tick(4);
        check("R11 parallel->serial keeps code", {2'b0, atten_code}, 8'h01);
        strobe_pulse();
        check("R13 shift reg intact after parallel", {2'b0, atten_code}, {2'b0, commit_of(exp_shift)});

        // random mix
        for (int it = 0; it < 24; it++) begin
            int op;
            logic [7:0] w;
            op = int'($urandom % 4);
            w  = 8'($urandom);
            case (op)
                0: begin
                    mode_serial = 1'b1; tick(4);
                    ser_word(w, 8); strobe_pulse();
                    check("R4 random 8-bit", {2'b0, atten_code}, {2'b0, exp_atten});
                end
                1: begin
                    mode_serial = 1'b1; tick(4);
                    ser_word(w, 6); strobe_pulse();
                    check("R5 random 6-bit", {2'b0, atten_code}, {2'b0, exp_atten});
                end
                2: begin
                    mode_serial = 1'b0; tick(4);
                    par_code = w[5:0]; tick(4);
                    check("R10 random hold", {2'b0, atten_code}, {2'b0, exp_atten});
                    strobe_pulse();
                    check("R10 random load", {2'b0, atten_code}, {2'b0, exp_atten});
                end
                default: begin
                    mode_serial = 1'b0; tick(4);
                    latch_en = 1'b1; par_code = w[5:0]; tick(4);
                    exp_atten = w[5:0];
                    check("R9 random follow", {2'b0, atten_code}, {2'b0, exp_atten});
                    latch_en = 1'b0; tick(4);
                end
            endcase
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule